// File: doc/BRIEF.md
# Multiplexed Display Scan Timer

This block drives an eight-position multiplexed character display from a single shared segment bus. A clock-enable pulse stands in for a slow oscillator. A prescaler divides these pulses by 64, and a character counter divides the result by 8. The character counter selects which character line is lit and also forms the read address of an external display buffer. The buffer returns a 6-bit code. A 64-entry glyph table turns that code into 17 segment lines, which are 16 strokes plus a decimal point.

Each character slot lasts 64 ticks. The first tick of each slot is a blanking gap in which no line is lit, so the segment pattern of one character never shows on its neighbour. While a buffer write is in progress, the scan keeps counting but every output is dark. A shutdown input also blinds all outputs and resets the divider chain to the start of character 0. The buffer contents are not touched.

Top module: `disp_scan_timer`

## Requirements
- R1: While rst_ni is low, char_o and seg_o are all zero and rd_addr_o is 0.
- R2: char_o[k] drives character position k, where bit 0 is the leftmost position. With a tick every cycle, the lit position advances by one every 64 ticks and wraps from 7 to 0. As a result, position 0 lights again exactly 512 ticks after it last lit.
- R3: In the first tick period of every character slot (prescaler count 0), char_o and seg_o are all zero.
- R4: char_o never has more than one bit set, and seg_o is all zero whenever char_o is all zero.
- R5: rd_addr_o equals the index of the current character slot while wr_active_i is low, and reads 0 while wr_active_i is high.
- R6: In the cycle after wr_active_i is sampled high, char_o and seg_o are all zero. The scan counters keep advancing during the write.
- R7: In the cycle after shutdown_i is sampled high, char_o and seg_o are zero and the divider chain is cleared. After release, the scan restarts at character 0 with a blanking gap.
- R8: seg_o is the glyph of the code read at rd_addr_o, registered one cycle later. Code 6'h20 maps to all segments off. Any other code c maps to {c, ~c, c[4:0] ^ {5{c[5]}}}, with the MSB first.
- R9: The counters move only in cycles where tick_i is high. Cycles without a tick leave the scan position and the blanking state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Single-cycle oscillator tick (clock enable) |
| shutdown_i | input | 1 | Blank outputs and clear the divider chain |
| wr_active_i | input | 1 | A buffer write is in progress; blanks outputs |
| rd_addr_o | output | 3 | Display buffer read address |
| rd_data_i | input | 6 | Character code read from the buffer |
| char_o | output | 8 | One-hot character line drive |
| seg_o | output | 17 | Segment line drive (16 strokes and a decimal point) |

## Verification
The first pattern is a continuous tick stream. It pins the exact 64-tick slot length, the single-tick gap at each slot start, and the 512-tick refresh period, all of which would blur under sparse ticks. The second pattern uses randomly sparse ticks, which separate tick-gated counting from free-running counting. The third pattern overlays random write windows and shutdown pulses on the scan. Write windows must darken the outputs without losing the scan position. Shutdown must return the scan to character 0. Buffer contents are re-randomised during the run, so every glyph path, including the blank code, is compared against the formula.

// File: rtl/disp_scan_pkg.sv
`timescale 1ns/1ps
package disp_scan_pkg;
  localparam int CODE_W = 6;
  localparam int SEG_W  = 17;
  localparam logic [CODE_W-1:0] BLANK_CODE = 6'h20;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // placeholder glyph set; real fonts replace this function
  function automatic seg_t glyph(input code_t c);
    if (c == BLANK_CODE) return '0;
    return {c, ~c, c[4:0] ^ {5{c[5]}}};
  endfunction
endpackage

// File: rtl/scan_prescaler.sv
`timescale 1ns/1ps
module scan_prescaler #(
  parameter int DIV = 64,
  localparam int CW = $clog2(DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (cnt_q == LAST);

  // R9
  pre_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(cnt_q));
  // R7
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/scan_char_counter.sv
`timescale 1ns/1ps
module scan_char_counter #(
  parameter int NUM = 8,
  localparam int IW = $clog2(NUM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] idx_q;
  localparam logic [IW-1:0] LAST = IW'(NUM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (step_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R2
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(idx_q));
endmodule

// File: rtl/scan_font.sv
`timescale 1ns/1ps
module scan_font
  import disp_scan_pkg::*;
#(
  localparam int ENTRIES = 2 ** CODE_W
) (
  input  code_t code_i,
  output seg_t  seg_o
);
  seg_t rom [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
    assign rom[i] = glyph(CODE_W'(i));
  end

  assign seg_o = rom[code_i];
endmodule

// File: rtl/scan_out_stage.sv
`timescale 1ns/1ps
module scan_out_stage
  import disp_scan_pkg::*;
#(
  parameter int NUM = 8,
  localparam int IW = $clog2(NUM)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gap_i,
  input  logic           wr_i,
  input  logic           off_i,
  input  logic [IW-1:0]  sel_i,
  input  seg_t           seg_i,
  output logic [NUM-1:0] char_o,
  output seg_t           seg_o
);
  logic [NUM-1:0] dec;
  logic           dark;

  for (genvar k = 0; k < NUM; k++) begin : g_dec
    assign dec[k] = (sel_i == IW'(k));
  end

  assign dark = gap_i | wr_i | off_i;

  // both registered together so lines and segments never disagree
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      char_o <= '0;
      seg_o  <= '0;
    end else begin
      char_o <= dark ? '0 : dec;
      seg_o  <= dark ? '0 : seg_i;
    end
  end

  // R4
  char_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(char_o));
  // R4
  seg_needs_char_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_o == '0) |-> (seg_o == '0));
  // R6
  wr_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (char_o == '0 && seg_o == '0));
  // R7
  off_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_i |=> (char_o == '0 && seg_o == '0));
endmodule

// File: rtl/disp_scan_timer.sv
`timescale 1ns/1ps
module disp_scan_timer
  import disp_scan_pkg::*;
#(
  parameter int PRE_DIV   = 64,
  parameter int NUM_CHARS = 8,
  localparam int PW = $clog2(PRE_DIV),
  localparam int IW = $clog2(NUM_CHARS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 shutdown_i,
  input  logic                 wr_active_i,
  output logic [IW-1:0]        rd_addr_o,
  input  logic [CODE_W-1:0]    rd_data_i,
  output logic [NUM_CHARS-1:0] char_o,
  output logic [SEG_W-1:0]     seg_o
);
  logic [PW-1:0] pre_cnt;
  logic          pre_wrap;
  logic [IW-1:0] chr_idx;
  seg_t          glyph_seg;

  scan_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(shutdown_i), .tick_i(tick_i),
    .cnt_o (pre_cnt), .wrap_o(pre_wrap)
  );

  scan_char_counter #(.NUM(NUM_CHARS)) u_chr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(shutdown_i), .step_i(pre_wrap),
    .idx_o(chr_idx)
  );

  // writer owns the buffer port during a write
  assign rd_addr_o = wr_active_i ? '0 : chr_idx;

  scan_font u_font (.code_i(rd_data_i), .seg_o(glyph_seg));

  scan_out_stage #(.NUM(NUM_CHARS)) u_out (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .gap_i (pre_cnt == '0), .wr_i(wr_active_i), .off_i(shutdown_i),
    .sel_i (chr_idx), .seg_i(glyph_seg),
    .char_o(char_o), .seg_o(seg_o)
  );

  // R3
  gap_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_cnt == '0) |=> (char_o == '0));
endmodule

// File: tb/disp_scan_timer_tb_top.sv
`timescale 1ns/1ps
module disp_scan_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        shutdown_i = 1'b0;
  logic        wr_active_i = 1'b0;
  logic [2:0]  rd_addr_o;
  logic [5:0]  rd_data_i;
  logic [7:0]  char_o;
  logic [16:0] seg_o;

  logic [5:0] mem [8];
  int n_chk = 0, n_err = 0, cyc = 0, last_rise = -1;
  int m_pre = 0, m_chr = 0;
  bit track = 0, prev0 = 0, done = 0;

  always #10 clk_i = ~clk_i;

  assign rd_data_i = mem[rd_addr_o];

  disp_scan_timer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .shutdown_i(shutdown_i),
    .wr_active_i(wr_active_i), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .char_o(char_o), .seg_o(seg_o)
  );

  function automatic logic [16:0] exp_glyph(input logic [5:0] c);
    if (c == 6'h20) return '0;
    return {c, ~c, c[4:0] ^ {5{c[5]}}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit t, input bit sd, input bit wr);
    logic [7:0]  ec;
    logic [16:0] es;
    bit dark;
    @(negedge clk_i);
    tick_i = t; shutdown_i = sd; wr_active_i = wr;
    #1;
    // R5
    chk(rd_addr_o == (wr ? 3'd0 : 3'(m_chr)), "R5 rd_addr", 32'(rd_addr_o), wr ? 0 : m_chr);
    dark = sd || wr || (m_pre == 0);  // R3 gap, R6 write, R7 shutdown
    ec = dark ? 8'h0 : (8'h1 << m_chr);
    es = dark ? 17'h0 : exp_glyph(mem[m_chr]);
    if (sd) begin m_pre = 0; m_chr = 0; end
    else if (t) begin
      if (m_pre == 63) begin m_pre = 0; m_chr = (m_chr + 1) % 8; end
      else m_pre++;
    end
    @(posedge clk_i); #1;
    cyc++;
    // R2 R3 R6 R7 R9 char lines
    chk(char_o == ec, "R2/R3/R6/R7/R9 char_o", 32'(char_o), 32'(ec));
    // R8 R4 segments
    chk(seg_o == es, "R8/R4 seg_o", 32'(seg_o), 32'(es));
    if (track && char_o[0] && !prev0) begin
      // R2 refresh period
      if (last_rise >= 0) chk(cyc - last_rise == 512, "R2 period", 32'(cyc - last_rise), 512);
      last_rise = cyc;
    end
    prev0 = char_o[0];
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) mem[i] = 6'($urandom);
    mem[3] = 6'h20;  // blank code on one position
    #35;
    // R1 reset state
    chk(char_o == 0, "R1 char_o", 32'(char_o), 0);
    chk(seg_o == 0, "R1 seg_o", 32'(seg_o), 0);
    chk(rd_addr_o == 0, "R1 rd_addr", 32'(rd_addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;

    // continuous ticks: slot length, gap, refresh period
    track = 1;
    for (int i = 0; i < 1600; i++) step(1, 0, 0);
    track = 0;

    // R9 idle: no ticks, nothing moves
    for (int i = 0; i < 40; i++) step(0, 0, 0);

    // R7 shutdown mid-scan, then restart from character 0
    for (int i = 0; i < 200; i++) step(1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 0);
    for (int i = 0; i < 130; i++) step(1, 0, 0);

    // R6 long write window keeps scan counting
    for (int i = 0; i < 100; i++) step(1, 0, 1);
    for (int i = 0; i < 100; i++) step(1, 0, 0);

    // random mix: sparse ticks, writes, shutdowns, changing buffer
    for (int i = 0; i < 30000; i++) begin
      if ($urandom_range(0, 99) == 0) mem[$urandom_range(0, 7)] = 6'($urandom);
      if ($urandom_range(0, 199) == 0) mem[$urandom_range(0, 7)] = 6'h20;
      step($urandom_range(0, 2) == 0 || i % 5000 < 1000,
           $urandom_range(0, 299) == 0,
           $urandom_range(0, 15) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule